// File: doc/BRIEF.md
# Serial Frame Length Guard

This block watches a serial command port that has two active-low selects. While either select is low, it counts the serial clock rising edges it is told about and, when the last select goes high, decides whether the number of bits was an accepted length. A legal frame gives a one-cycle strobe that the register stage uses to capture the shifted-in word. An illegal frame blocks that capture and sets a sticky transmission-error flag.

The error flag is reported at the start of the following frame. It appears on the leading serial-out bit, ORed with the incoming serial data, so an error raised anywhere in a daisy chain reaches the controller. The flag is also raised when the device comes out of power-on reset and when it leaves the low-power disabled state. Every input is a synchronized level or a one-cycle strobe in the system clock domain.

Top module: `frame_len_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `err_flag` is 1, `frame_ok` is 0 and `sdo_lead` is 0.
- R2: When only one select was low during a frame, a count of 16, or 16 plus any multiple of 8, is legal. In the clock cycle after the cycle in which both selects are first sampled high, `frame_ok` is 1 and `err_flag` is 0.
- R3: When only one select was low during a frame, any other nonzero count leaves `frame_ok` at 0 and sets `err_flag` to 1 in that same cycle.
- R4: When both selects were low together during a frame, the minimum is 32 bits, extendable by multiples of 8. Counts of 16 or 24 in that case are illegal.
- R5: Once both selects have been low together in a frame, the 32-bit rule applies until both are high. This holds even if one select rises before the other, or if the second select falls partway through the frame.
- R6: A frame with no serial clock edges leaves `frame_ok` at 0 and does not change `err_flag`.
- R7: A pulse on `por_exit` or `wake_exit` sets `err_flag` one cycle later. If it arrives in the same cycle that a legal frame ends, the set wins: `frame_ok` still pulses, and `err_flag` is 1.
- R8: While a select is low and no clock edge has been counted yet, `sdo_lead` equals `err_flag | sdi`. It is 0 after the first counted edge and whenever both selects are high.
- R9: A frame longer than 2**CNT_W-1 bits is illegal, even if its length would otherwise fit the 8-bit grid.
- R10: `frame_ok` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, models power-on reset |
| sel_a_n | input | 1 | Synchronized first select, active low |
| sel_b_n | input | 1 | Synchronized second select, active low |
| sclk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| por_exit | input | 1 | Strobe: device leaves power-on reset |
| wake_exit | input | 1 | Strobe: device leaves the enable-low state |
| sdi | input | 1 | Incoming serial data bit |
| frame_ok | output | 1 | One-cycle strobe: legal frame, capture the input word |
| err_flag | output | 1 | Sticky transmission-error flag |
| sdo_lead | output | 1 | Leading serial-out bit, error flag ORed with sdi |

## Verification
The clearing of the error flag by a legal frame and its setting by a power or wake exit can happen in the same cycle. The bench provokes this by driving `por_exit` in the same cycle in which both selects return high after a legal 16-bit frame. It then expects `frame_ok` high and `err_flag` high in the following cycle, because the set takes priority. The bench also closes a frame with the selects rising at different times after both were low, to confirm that the wider rule persists across that step.

// File: rtl/flg_pkg.sv
package flg_pkg;
   typedef enum logic [1:0] {
      V_EMPTY = 2'd0,
      V_GOOD  = 2'd1,
      V_BAD   = 2'd2
   } verdict_t;
endpackage

// File: rtl/flg_bitcount.sv
module flg_bitcount #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             sat
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sat <= 1'b0;
      end else if (!active) begin
         cnt <= '0;
         sat <= 1'b0;
      end else if (tick) begin
         if (cnt == CNT_MAX) sat <= 1'b1;
         else                cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/flg_span.sv
module flg_span (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_a_n,
   input  logic sel_b_n,
   output logic active,
   output logic end_s,
   output logic wide_q
);
   logic active_q;

   assign active = ~sel_a_n | ~sel_b_n;
   assign end_s  = active_q & ~active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         wide_q   <= 1'b0;
      end else begin
         active_q <= active;
         if (!active)                    wide_q <= 1'b0;
         else if (!sel_a_n && !sel_b_n)  wide_q <= 1'b1;
      end
   end
endmodule

// File: rtl/flg_rule.sv
module flg_rule
   import flg_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int MIN_ONE  = 16,
   parameter int MIN_BOTH = 32,
   parameter int STEP     = 8
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             sat,
   input  logic             wide,
   output verdict_t         verdict
);
   localparam logic [CNT_W-1:0] NEED_ONE  = MIN_ONE[CNT_W-1:0];
   localparam logic [CNT_W-1:0] NEED_BOTH = MIN_BOTH[CNT_W-1:0];
   localparam bit STEP_POW2 = ((STEP & (STEP - 1)) == 0);

   logic [CNT_W-1:0] need;
   logic [CNT_W-1:0] extra;
   logic             on_grid;

   assign need  = wide ? NEED_BOTH : NEED_ONE;
   assign extra = cnt - need;

   generate
      if (STEP_POW2 && STEP == 1) begin : g_any
         assign on_grid = 1'b1;
      end else if (STEP_POW2) begin : g_mask
         localparam int SB = $clog2(STEP);
         assign on_grid = ~|extra[SB-1:0];
      end else begin : g_div
         localparam logic [CNT_W-1:0] STEP_V = STEP[CNT_W-1:0];
         assign on_grid = ((extra % STEP_V) == '0);
      end
   endgenerate

   always_comb begin
      if (sat)                       verdict = V_BAD;
      else if (cnt == '0)            verdict = V_EMPTY;
      else if (cnt >= need && on_grid) verdict = V_GOOD;
      else                           verdict = V_BAD;
   end
endmodule

// File: rtl/flg_sticky.sv
module flg_sticky
   import flg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     end_s,
   input  verdict_t verdict,
   input  logic     set_req,
   output logic     err_q,
   output logic     ok_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b1;
         ok_q  <= 1'b0;
      end else begin
         ok_q <= end_s && (verdict == V_GOOD);
         if (set_req)
            err_q <= 1'b1;
         else if (end_s && verdict == V_GOOD)
            err_q <= 1'b0;
         else if (end_s && verdict == V_BAD)
            err_q <= 1'b1;
      end
   end
endmodule

// File: rtl/frame_len_guard.sv
module frame_len_guard
   import flg_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int MIN_ONE  = 16,
   parameter int MIN_BOTH = 32,
   parameter int STEP     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_a_n,
   input  logic sel_b_n,
   input  logic sclk_rise,
   input  logic por_exit,
   input  logic wake_exit,
   input  logic sdi,
   output logic frame_ok,
   output logic err_flag,
   output logic sdo_lead
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (STEP < 1)               begin : g_bad_step  $error("STEP must be at least 1"); end
      if (MIN_ONE < 1)            begin : g_bad_min   $error("MIN_ONE must be at least 1"); end
      if (MIN_BOTH < MIN_ONE)     begin : g_bad_order $error("MIN_BOTH below MIN_ONE"); end
      if (MIN_BOTH > CNT_MAX)     begin : g_bad_width $error("CNT_W too small for MIN_BOTH"); end
   endgenerate

   logic             active;
   logic             end_s;
   logic             wide_q;
   logic [CNT_W-1:0] cnt;
   logic             sat;
   verdict_t         verdict;

   flg_span u_span (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_a_n (sel_a_n),
      .sel_b_n (sel_b_n),
      .active  (active),
      .end_s   (end_s),
      .wide_q  (wide_q)
   );

   flg_bitcount #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .tick   (sclk_rise),
      .cnt    (cnt),
      .sat    (sat)
   );

   flg_rule #(
      .CNT_W    (CNT_W),
      .MIN_ONE  (MIN_ONE),
      .MIN_BOTH (MIN_BOTH),
      .STEP     (STEP)
   ) u_rule (
      .cnt     (cnt),
      .sat     (sat),
      .wide    (wide_q),
      .verdict (verdict)
   );

   flg_sticky u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .end_s   (end_s),
      .verdict (verdict),
      .set_req (por_exit | wake_exit),
      .err_q   (err_flag),
      .ok_q    (frame_ok)
   );

   assign sdo_lead = (active && cnt == '0 && !sat) ? (err_flag | sdi) : 1'b0;
endmodule

// File: rtl/flg_guard_chk.sv
module flg_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic sel_a_n,
   input logic sel_b_n,
   input logic por_exit,
   input logic wake_exit,
   input logic frame_ok,
   input logic err_flag,
   input logic sdo_lead
);
   p_ok_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> !frame_ok);

   p_ok_after_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_ok) |-> $past(sel_a_n && sel_b_n));

   p_ok_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok && !$past(por_exit || wake_exit)) |-> !err_flag);

   p_exit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (por_exit || wake_exit) |=> err_flag);

   p_lead_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a_n && sel_b_n) |-> !sdo_lead);

   p_hold_midframe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((!sel_a_n || !sel_b_n) && !por_exit && !wake_exit) |=> $stable(err_flag));
endmodule

bind frame_len_guard flg_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_a_n   (sel_a_n),
   .sel_b_n   (sel_b_n),
   .por_exit  (por_exit),
   .wake_exit (wake_exit),
   .frame_ok  (frame_ok),
   .err_flag  (err_flag),
   .sdo_lead  (sdo_lead)
);

// File: tb/sim_frame_len_guard.sv
`timescale 1ns/1ps
module sim_frame_len_guard;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sa = 1'b1, sb = 1'b1, sclk = 1'b0, por = 1'b0, wake = 1'b0, sdi = 1'b0;
   logic frame_ok, err_flag, sdo_lead;
   int   total = 0, bad = 0;
   logic err_m;
   bit   done = 0;

   always #2.5 clk = ~clk;

   frame_len_guard u0 (
      .clk (clk), .rst_n (rst_n), .sel_a_n (sa), .sel_b_n (sb),
      .sclk_rise (sclk), .por_exit (por), .wake_exit (wake), .sdi (sdi),
      .frame_ok (frame_ok), .err_flag (err_flag), .sdo_lead (sdo_lead)
   );

   // mode: 0 first select only, 1 second select only, 2 both; exp_ok
   localparam int VEC [0:9][0:2] = '{
      '{0, 16, 1}, '{0, 24, 1}, '{0, 20, 0}, '{1, 16, 1}, '{2, 16, 0},
      '{2, 32, 1}, '{2, 40, 1}, '{1, 8, 0},  '{0, 0, 0},  '{2, 24, 0}
   };

   task automatic check(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b", req, act, exp);
      end
   endtask

   task automatic open_sel(int mode);
      @(negedge clk);
      sa = (mode == 1);
      sb = (mode == 0);
   endtask

   task automatic clocks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sclk = 1'b1;
         @(negedge clk); sclk = 1'b0;
      end
   endtask

   task automatic close_sel();
      @(negedge clk); sa = 1'b1; sb = 1'b1;
      @(posedge clk); #1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 err in reset", err_flag, 1'b1);
      check("R1 ok in reset", frame_ok, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 err after reset", err_flag, 1'b1);
      check("R1 lead after reset", sdo_lead, 1'b0);
      err_m = 1'b1;

      for (int v = 0; v < 10; v++) begin
         string tag;
         logic  okx;
         okx = VEC[v][2][0];
         if (VEC[v][1] == 0)     tag = "R6 zero clocks";
         else if (VEC[v][0] == 2) tag = "R4 both selects";
         else if (okx)            tag = "R2 legal length";
         else                     tag = "R3 illegal length";
         open_sel(VEC[v][0]);
         clocks(VEC[v][1]);
         close_sel();
         if (VEC[v][1] != 0) err_m = !okx;
         check(tag, frame_ok, okx);
         check(tag, err_flag, err_m);
         @(posedge clk); #1;
         check("R10 single pulse", frame_ok, 1'b0);
      end

      // R8: leading bit before and after first edge (err currently 1)
      open_sel(0); sdi = 1'b0; #1;
      check("R8 lead shows err", sdo_lead, 1'b1);
      clocks(1); #1;
      check("R8 lead gone after edge", sdo_lead, 1'b0);
      clocks(15);
      close_sel();
      check("R2 legal clears", err_flag, 1'b0);
      open_sel(1); sdi = 1'b0; #1;
      check("R8 lead zero err zero sdi", sdo_lead, 1'b0);
      sdi = 1'b1; #1;
      check("R8 lead ORs sdi", sdo_lead, 1'b1);
      sdi = 1'b0;
      close_sel();
      check("R6 zero frame keeps err", err_flag, 1'b0);
      check("R6 zero frame no ok", frame_ok, 1'b0);

      // R5: second select joins mid-frame, leaves early; 16 bits illegal
      open_sel(0); clocks(4);
      @(negedge clk); sb = 1'b0; clocks(4);
      @(negedge clk); sb = 1'b1; clocks(8);
      close_sel();
      check("R5 wide sticks", frame_ok, 1'b0);
      check("R5 wide sticks err", err_flag, 1'b1);
      // R5: both low, one rises early, 32 bits legal
      open_sel(2); clocks(32);
      @(negedge clk); sb = 1'b1;
      @(negedge clk);
      close_sel();
      check("R5 staggered rise ok", frame_ok, 1'b1);
      check("R5 staggered rise err", err_flag, 1'b0);

      // R7: por coincides with legal close; set wins
      open_sel(0); clocks(16);
      @(negedge clk); sa = 1'b1; sb = 1'b1; por = 1'b1;
      @(posedge clk); #1;
      check("R7 ok with coincident set", frame_ok, 1'b1);
      check("R7 set wins", err_flag, 1'b1);
      @(negedge clk); por = 1'b0;
      open_sel(1); clocks(16); close_sel();
      check("R2 clear again", err_flag, 1'b0);
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0; #1;
      check("R7 wake sets", err_flag, 1'b1);
      open_sel(0); clocks(16); close_sel();
      check("R2 clear after wake", err_flag, 1'b0);

      // R9: 264 bits is on the grid but beyond the counter range
      open_sel(0); clocks(264); close_sel();
      check("R9 overlong rejected", frame_ok, 1'b0);
      check("R9 overlong err", err_flag, 1'b1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule